// File: doc/BRIEF.md
# Power-Down Entry and Wake Controller

This block manages the low-power state of a small microcontroller core. The CPU asks to sleep with a single-cycle request. If the request is accepted, the block turns off the oscillator enable and stops the core-run signal, so nothing executes after the instruction that made the request. While asleep, the block watches two active-low external interrupt pins, each with its own enable, and the hardware reset. A free-running reference timer clocks the block and keeps running through the sleep period. Every duration is a parameter counted in cycles of that timer.

An interrupt wakeup counts only once a synchronized pin has stayed low for a start-up interval that stands in for oscillator settling. A configuration bit then chooses when the core resumes. With the bit set to 1, the core resumes when the pin goes high again. With the bit set to 0, the core resumes a fixed self-timed interval after the pin went low. On resume the block gives a one-cycle strobe with the index of the pin that caused the wakeup. A hardware reset also ends sleep. It takes priority over an interrupt wakeup and raises a register-reinitialisation request; no memory-clear request exists. After any resume, whether from reset or from an interrupt, a guard window refuses new sleep requests. A request refused this way is dropped, not held.

Top module: `pdwake_ctrl`

## Requirements
- R1: A request accepted on a clock edge (`pd_req_i`=1, `core_run_o`=1, `entry_blk_o`=0) drives both `osc_en_o` and `core_run_o` to 0 from the next cycle.
- R2: While asleep, only `rst` or an enabled pin can end sleep. A pin whose `int_en_i` bit is 0 has no effect, even if held low without limit, and `pd_req_i` is ignored.
- R3: Each pin passes through a two-flop synchronizer. A pin driven low before clock edge 1 and high again before edge L+1 qualifies a wakeup only if L >= STARTUP_CYC. A shorter low pulse leaves the block asleep.
- R4: With the mode bit at 1, the core resumes on the pin's return high. After a qualified low of L edges (defined as in R3), `core_run_o` is first 1 after edge L+3.
- R5: With the mode bit at 0, `core_run_o` is first 1 after edge SELF_CYC+2, counted from the pin going low before edge 1. This holds however long the pin stays low. SELF_CYC must exceed STARTUP_CYC.
- R6: `wake_int_o` is 1 for exactly the first cycle in which `core_run_o` is 1 after an interrupt wakeup. In that cycle `wake_src_o` gives the pin index. If several enabled pins qualify on the same edge, the lowest index wins.
- R7: `osc_en_o` is 0 only while asleep. It returns to 1 on edge STARTUP_CYC+2 after the qualifying pin fell. `core_run_o` stays 0 until the resume point.
- R8: While `rst` is sampled high and for one edge after it is released, `sfr_reset_o`=1, `osc_en_o`=1, `core_run_o`=0 and `wake_int_o`=0. The edge that samples `rst` low sets `core_run_o` to 1. This holds whether the core was asleep or running.
- R9: If `rst` is sampled high on the edge where an interrupt resume would happen, the reset wins and no `wake_int_o` strobe is produced.
- R10: `entry_blk_o` is 1 for exactly GUARD_CYC cycles, starting with the first cycle of `core_run_o`=1 after any resume. A request made while the guard is active is dropped and is not acted on later. A request in the first unguarded cycle is accepted.
- R11: The mode bit is written with `cfg_we_i`/`cfg_mode_i` and clears to 0 on reset. After a reset the block uses R5 timing until the bit is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference timer clock, runs through sleep |
| rst | input | 1 | Hardware reset, synchronous, active high; also a wake source |
| pd_req_i | input | 1 | One-cycle sleep request from the CPU |
| cfg_we_i | input | 1 | Write strobe for the wake-mode bit |
| cfg_mode_i | input | 1 | Wake-mode value: 1 = resume on rising edge, 0 = self-timed |
| int_en_i | input | NPIN | Per-pin interrupt wake enable |
| int_n_i | input | NPIN | External interrupt pins, active low, asynchronous |
| osc_en_o | output | 1 | Oscillator enable |
| core_run_o | output | 1 | Core may execute |
| sfr_reset_o | output | 1 | Reinitialise special-function registers |
| wake_int_o | output | 1 | One-cycle strobe on interrupt resume |
| wake_src_o | output | SRC_W | Index of the waking pin |
| entry_blk_o | output | 1 | Sleep requests are refused this cycle |

## Verification
The checker tests on every cycle the relations between the output signals. It checks that an accepted request shuts the core and oscillator on the next cycle, and that a request made during the guard window leaves the core running. It also checks that the core never starts except through a reset release or a strobed interrupt wakeup, that the strobe lasts one cycle and lines up with the core's restart, and that the oscillator is never off while the core runs or while a register reset is pending. Only the bench scenarios can show the exact cycle counts: the qualification threshold, the resume latency in each mode, the length of the guard, which pin wins when two qualify together, a refused request not being carried out later, and a reset winning over a wakeup on the same edge.

// File: rtl/pdwake_pkg.sv
package pdwake_pkg;

    // Sequencer states; the encoding is internal only.
    typedef enum logic [1:0] {
        ST_RST  = 2'd0,
        ST_RUN  = 2'd1,
        ST_DOWN = 2'd2,
        ST_WAKE = 2'd3
    } pd_state_t;

    // Control outputs that depend only on the sequencer state.
    typedef struct packed {
        logic osc_en;
        logic core_run;
        logic sfr_reset;
    } pd_ctl_t;

    function automatic pd_ctl_t decode_ctl(input pd_state_t s);
        pd_ctl_t c;
        c.osc_en    = (s != ST_DOWN);
        c.core_run  = (s == ST_RUN);
        c.sfr_reset = (s == ST_RST);
        return c;
    endfunction

    // Width of a counter that must hold values 0..max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

    // Width of a pin index.
    function automatic int idx_width(input int count);
        return (count < 2) ? 1 : $clog2(count);
    endfunction

endpackage

// File: rtl/pdwake_sync.sv
module pdwake_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    // Chain of flops per bit; resets to the idle (high) pin level.
    logic [N-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                chain[s] <= '1;
            end
        end else begin
            chain[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain[s] <= chain[s-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];

endmodule

// File: rtl/pdwake_lowqual.sv
module pdwake_lowqual
    import pdwake_pkg::*;
#(
    parameter int QUAL_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic watch_i,   // sequencer is asleep
    input  logic en_i,      // wake enable for this pin
    input  logic pin_s_i,   // synchronized pin, active low
    output logic qual_o
);
    localparam int QW = cnt_width(QUAL_CYC);
    localparam logic [QW-1:0] LAST = QW'(QUAL_CYC - 1);

    logic [QW-1:0] low_cnt;
    logic          armed;

    // Counting is only meaningful while asleep, enabled and low.
    assign armed = watch_i && en_i && !pin_s_i;

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            low_cnt <= '0;
        end else if (low_cnt != LAST) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // The QUAL_CYC-th consecutive low sample qualifies the wakeup.
    assign qual_o = armed && (low_cnt == LAST);

endmodule

// File: rtl/pdwake_guard.sv
module pdwake_guard
    import pdwake_pkg::*;
#(
    parameter int GUARD_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,   // a resume from sleep happens this edge
    input  logic tick_i,   // core is running
    output logic blk_o
);
    localparam int GW = cnt_width(GUARD_CYC);
    localparam logic [GW-1:0] FULL = GW'(GUARD_CYC);

    logic [GW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst || load_i) begin
            remain <= FULL;
        end else if (tick_i && (remain != '0)) begin
            remain <= remain - 1'b1;
        end
    end

    assign blk_o = (remain != '0);

endmodule

// File: rtl/pdwake_fsm.sv
module pdwake_fsm
    import pdwake_pkg::*;
#(
    parameter int NPIN        = 2,
    parameter int STARTUP_CYC = 1000,
    parameter int SELF_CYC    = 2000,
    parameter int SW          = idx_width(NPIN)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            pd_req_i,
    input  logic            blk_i,
    input  logic            mode_i,
    input  logic [NPIN-1:0] qual_i,
    input  logic [NPIN-1:0] pin_s_i,
    output pd_state_t       state_o,
    output logic            resume_o,
    output logic            wake_int_o,
    output logic [SW-1:0]   wake_src_o
);
    localparam int EW = cnt_width(SELF_CYC);
    localparam logic [EW-1:0] EL_START = EW'(STARTUP_CYC);
    localparam logic [EW-1:0] EL_DONE  = EW'(SELF_CYC - 1);

    pd_state_t     st_q, st_n;
    logic [SW-1:0] src_q, src_n;
    logic [EW-1:0] el_q;
    logic          hit;
    logic          self_done;
    logic          rise_seen;
    logic          resume_go;
    logic          wake_q;

    // Lowest qualifying pin index wins.
    always_comb begin
        hit   = 1'b0;
        src_n = src_q;
        for (int i = NPIN - 1; i >= 0; i--) begin
            if (qual_i[i]) begin
                hit   = 1'b1;
                src_n = SW'(i);
            end
        end
    end

    assign self_done = (el_q == EL_DONE);
    assign rise_seen = pin_s_i[src_q];
    assign resume_go = (st_q == ST_WAKE) && (mode_i ? rise_seen : self_done);

    always_comb begin
        st_n = st_q;
        unique case (st_q)
            ST_RST:  st_n = ST_RUN;
            ST_RUN:  if (pd_req_i && !blk_i) st_n = ST_DOWN;
            ST_DOWN: if (hit) st_n = ST_WAKE;
            ST_WAKE: if (resume_go) st_n = ST_RUN;
            default: st_n = ST_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_RST;
            src_q  <= '0;
            el_q   <= '0;
            wake_q <= 1'b0;
        end else begin
            st_q   <= st_n;
            wake_q <= resume_go;
            if ((st_q == ST_DOWN) && hit) begin
                src_q <= src_n;
                el_q  <= EL_START;   // low samples already seen
            end else if ((st_q == ST_WAKE) && !self_done) begin
                el_q <= el_q + 1'b1;
            end
        end
    end

    assign state_o    = st_q;
    assign resume_o   = resume_go;
    assign wake_int_o = wake_q;
    assign wake_src_o = src_q;

endmodule

// File: rtl/pdwake_ctrl.sv
module pdwake_ctrl
    import pdwake_pkg::*;
#(
    parameter  int NPIN        = 2,
    parameter  int STARTUP_CYC = 1000,
    parameter  int SELF_CYC    = 2000,
    parameter  int GUARD_CYC   = 4,
    localparam int SRC_W       = idx_width(NPIN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pd_req_i,
    input  logic             cfg_we_i,
    input  logic             cfg_mode_i,
    input  logic [NPIN-1:0]  int_en_i,
    input  logic [NPIN-1:0]  int_n_i,
    output logic             osc_en_o,
    output logic             core_run_o,
    output logic             sfr_reset_o,
    output logic             wake_int_o,
    output logic [SRC_W-1:0] wake_src_o,
    output logic             entry_blk_o
);
    logic [NPIN-1:0] pin_s;
    logic [NPIN-1:0] qual;
    pd_state_t       st;
    logic            in_down;
    logic            in_run;
    logic            resume;
    logic            blk;
    logic            mode_q;
    pd_ctl_t         ctl;

    assign in_down = (st == ST_DOWN);
    assign in_run  = (st == ST_RUN);

    // Wake-mode bit, cleared by reset.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
        end else if (cfg_we_i) begin
            mode_q <= cfg_mode_i;
        end
    end

    pdwake_sync #(
        .N      (NPIN),
        .STAGES (2)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i (int_n_i),
        .q_o (pin_s)
    );

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        pdwake_lowqual #(
            .QUAL_CYC (STARTUP_CYC)
        ) u_qual (
            .clk     (clk),
            .rst     (rst),
            .watch_i (in_down),
            .en_i    (int_en_i[g]),
            .pin_s_i (pin_s[g]),
            .qual_o  (qual[g])
        );
    end

    pdwake_guard #(
        .GUARD_CYC (GUARD_CYC)
    ) u_guard (
        .clk    (clk),
        .rst    (rst),
        .load_i (resume),
        .tick_i (in_run),
        .blk_o  (blk)
    );

    pdwake_fsm #(
        .NPIN        (NPIN),
        .STARTUP_CYC (STARTUP_CYC),
        .SELF_CYC    (SELF_CYC),
        .SW          (SRC_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .pd_req_i   (pd_req_i),
        .blk_i      (blk),
        .mode_i     (mode_q),
        .qual_i     (qual),
        .pin_s_i    (pin_s),
        .state_o    (st),
        .resume_o   (resume),
        .wake_int_o (wake_int_o),
        .wake_src_o (wake_src_o)
    );

    assign ctl         = decode_ctl(st);
    assign osc_en_o    = ctl.osc_en;
    assign core_run_o  = ctl.core_run;
    assign sfr_reset_o = ctl.sfr_reset;
    assign entry_blk_o = blk;

endmodule

// File: rtl/pdwake_ctrl_chk.sv
module pdwake_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic pd_req_i,
    input logic osc_en_o,
    input logic core_run_o,
    input logic sfr_reset_o,
    input logic wake_int_o,
    input logic entry_blk_o
);
    // R1: an accepted request stops core and oscillator next cycle
    p_enter_r1: assert property (@(posedge clk) disable iff (rst)
        core_run_o && pd_req_i && !entry_blk_o |=> !core_run_o && !osc_en_o);

    // R2: core never restarts straight from the oscillator-off state
    p_stay_down_r2: assert property (@(posedge clk) disable iff (rst)
        !osc_en_o |=> !core_run_o);

    // R6: strobe lines up with the core's restart and lasts one cycle
    p_strobe_rise_r6: assert property (@(posedge clk) disable iff (rst)
        wake_int_o |-> $rose(core_run_o));
    p_strobe_once_r6: assert property (@(posedge clk) disable iff (rst)
        wake_int_o |=> !wake_int_o);

    // R7: oscillator off only while core stopped and no reset pending
    p_osc_off_r7: assert property (@(posedge clk) disable iff (rst)
        !osc_en_o |-> !core_run_o && !sfr_reset_o);

    // R8: reset request keeps core stopped, oscillator on, no strobe
    p_sfr_r8: assert property (@(posedge clk) disable iff (rst)
        sfr_reset_o |-> !core_run_o && osc_en_o && !wake_int_o);
    p_start_src_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(core_run_o) |-> wake_int_o || $past(sfr_reset_o));

    // R10: guard opens with every resume; blocked request is dropped
    p_guard_open_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(core_run_o) |-> entry_blk_o);
    p_drop_r10: assert property (@(posedge clk) disable iff (rst)
        core_run_o && pd_req_i && entry_blk_o |=> core_run_o);

endmodule

bind pdwake_ctrl pdwake_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pd_req_i    (pd_req_i),
    .osc_en_o    (osc_en_o),
    .core_run_o  (core_run_o),
    .sfr_reset_o (sfr_reset_o),
    .wake_int_o  (wake_int_o),
    .entry_blk_o (entry_blk_o)
);

// File: tb/pdwake_ctrl_tb_top.sv
module pdwake_ctrl_tb_top;
    localparam int NPIN    = 2;
    localparam int STARTUP = 5;
    localparam int SELFT   = 12;
    localparam int GUARD   = 4;
    localparam int LIM     = 40;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       pd_req = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_mode = 1'b0;
    logic [1:0] int_en = 2'b00;
    logic [1:0] int_n = 2'b11;
    logic       osc_en, core_run, sfr_reset, wake_int, entry_blk;
    logic [0:0] wake_src;

    int total = 0;
    int bad = 0;

    pdwake_ctrl #(
        .NPIN        (NPIN),
        .STARTUP_CYC (STARTUP),
        .SELF_CYC    (SELFT),
        .GUARD_CYC   (GUARD)
    ) dut_i (
        .clk         (clk),
        .rst         (rst),
        .pd_req_i    (pd_req),
        .cfg_we_i    (cfg_we),
        .cfg_mode_i  (cfg_mode),
        .int_en_i    (int_en),
        .int_n_i     (int_n),
        .osc_en_o    (osc_en),
        .core_run_o  (core_run),
        .sfr_reset_o (sfr_reset),
        .wake_int_o  (wake_int),
        .wake_src_o  (wake_src),
        .entry_blk_o (entry_blk)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at the negedge where core_run first reads 1; returns at the
    // first negedge with entry_blk low.
    task automatic measure_guard(input string req);
        int n = 0;
        while (entry_blk && n < 100) begin
            n++;
            @(negedge clk);
            if (n == 1) check({req, " strobe one cycle R6"}, int'(wake_int), 0);
        end
        check({req, " guard length R10"}, n, GUARD);
    endtask

    // Returns at the negedge where core_run first reads 1 after release.
    task automatic do_reset(input bit do_checks);
        @(negedge clk);
        int_n = 2'b11;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        if (do_checks) begin
            check("R8 sfr_reset during reset", int'(sfr_reset), 1);
            check("R8 core_run during reset", int'(core_run), 0);
            check("R8 osc_en during reset", int'(osc_en), 1);
        end
        rst = 1'b0;
        @(negedge clk);
        if (do_checks) begin
            check("R8 core_run after release", int'(core_run), 1);
            check("R8 sfr_reset after release", int'(sfr_reset), 0);
            check("R8 no strobe on reset resume", int'(wake_int), 0);
        end
    endtask

    task automatic set_cfg(input bit m);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_mode = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Call at a negedge with entry_blk low and core running.
    task automatic enter_pd();
        pd_req = 1'b1;
        @(negedge clk);
        pd_req = 1'b0;
        check("R1 core stops", int'(core_run), 0);
        check("R1 oscillator stops", int'(osc_en), 0);
    endtask

    // kind: 0 other pin idle, 1 other pin held low all trial, 2 other mirrors pin
    task automatic wake_trial(input bit mode, input bit wcfg, input int pin,
                              input logic [1:0] en, input int L, input int kind);
        int  other = 1 - pin;
        int  first = 0;
        int  osc_first = 0;
        int  ws = 0;
        int  wi = 0;
        bit  q_pin, q_oth, qual_any;
        bit  emode;
        int  exp_src, exp_n;
        do_reset(1'b0);
        measure_guard("trial setup");
        if (wcfg) set_cfg(mode);
        emode = wcfg ? mode : 1'b0;
        int_en = en;
        @(negedge clk);
        enter_pd();
        int_n[pin] = 1'b0;
        if (kind != 0) int_n[other] = 1'b0;
        for (int n = 1; n <= LIM; n++) begin
            @(negedge clk);
            if (n == L) begin
                int_n[pin] = 1'b1;
                if (kind == 2) int_n[other] = 1'b1;
            end
            if (osc_en && osc_first == 0) osc_first = n;
            if (core_run && first == 0) begin
                first = n;
                wi = int'(wake_int);
                ws = int'(wake_src);
                break;
            end
        end
        q_pin    = en[pin] && (L >= STARTUP);
        q_oth    = (kind == 2) && en[other] && (L >= STARTUP);
        qual_any = q_pin || q_oth;
        exp_src  = (q_pin && q_oth) ? 0 : (q_pin ? pin : other);
        exp_n    = emode ? (L + 3) : (SELFT + 2);
        if (!qual_any) begin
            check("R3/R2 no wake without qualified enabled pin", first, 0);
            check("R2 oscillator stays off", osc_first, 0);
            pd_req = 1'b1;
            @(negedge clk);
            pd_req = 1'b0;
            @(negedge clk);
            check("R2 request while asleep ignored", int'(core_run) + int'(osc_en), 0);
        end else begin
            check(emode ? "R4 rising-edge resume cycle" : "R5 self-timed resume cycle",
                  first, exp_n);
            check("R7 oscillator restart cycle", osc_first, STARTUP + 2);
            check("R6 strobe with restart", wi, 1);
            check("R6 source pin / priority", ws, exp_src);
            measure_guard("wake");
        end
        int_n = 2'b11;
        int_en = 2'b00;
    endtask

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        check("R8 reset state sfr_reset", int'(sfr_reset), 1);
        check("R8 reset state core_run", int'(core_run), 0);
        check("R8 reset state osc_en", int'(osc_en), 1);
        check("R8 reset state strobe", int'(wake_int), 0);
        check("R10 reset state guard", int'(entry_blk), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R8 first run cycle", int'(core_run), 1);
        measure_guard("R8 reset release");

        // R10: blocked request dropped, not queued; first open cycle accepted
        do_reset(1'b1);
        pd_req = 1'b1;
        @(negedge clk);
        pd_req = 1'b0;
        check("R10 blocked request dropped", int'(core_run), 1);
        repeat (GUARD + 3) @(negedge clk);
        check("R10 dropped request not queued", int'(core_run), 1);
        check("R10 guard open", int'(entry_blk), 0);
        enter_pd();
        // R8: reset from sleep
        repeat (5) @(negedge clk);
        check("R2 stays asleep without stimulus", int'(core_run), 0);
        do_reset(1'b1);
        measure_guard("R8 reset from sleep");
        enter_pd();

        // Sweep: mode x pin x enables x low length
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int e = 0; e < 4; e++) begin
                    for (int k = 0; k < 3; k++) begin
                        int L = (k == 0) ? STARTUP - 1 : ((k == 1) ? STARTUP : STARTUP + 3);
                        logic [1:0] en = 2'(e);
                        int kind = en[1-p] ? 2 : 1;
                        wake_trial(m[0], 1'b1, p, en, L, kind);
                    end
                end
            end
        end

        // R11: mode bit returns to 0 after reset
        set_cfg(1'b1);
        wake_trial(1'b1, 1'b0, 0, 2'b01, STARTUP + 1, 0);
        wake_trial(1'b0, 1'b0, 1, 2'b10, STARTUP, 0);

        // R9: reset on the resume edge wins
        do_reset(1'b0);
        measure_guard("R9 setup");
        int_en = 2'b01;
        enter_pd();
        int_n[0] = 1'b0;
        for (int n = 1; n <= SELFT + 1; n++) begin
            @(negedge clk);
            if (n == STARTUP) int_n[0] = 1'b1;
        end
        rst = 1'b1;
        @(negedge clk);
        check("R9 reset wins: no strobe", int'(wake_int), 0);
        check("R9 reset wins: sfr_reset", int'(sfr_reset), 1);
        check("R9 reset wins: core stopped", int'(core_run), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9 resume from reset", int'(core_run), 1);
        check("R9 no strobe after reset", int'(wake_int), 0);
        int_en = 2'b00;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule